// File: doc/BRIEF.md
# Shared Wall-Clock Compare Timer

This block is a memory-mapped timer that several processor cores share. It holds one free-running 64-bit wall-clock counter and two independent compare channels. Each channel drives its own interrupt line, and every core reads the same counter, so all of them see one time base. Software reaches the block through a plain 32-bit register bus. Every 64-bit quantity is therefore split into a low word and a high word.

Each channel has an enable ("armed") bit and a sticky "fired" bit, and both sit in a shared control register. Software disarms a channel, writes the new compare value in two halves, and then arms the channel again. The new value reaches the matcher only at that re-arm, so a half-written compare can never fire the channel. The fired bit is cleared by writing 1 to it. A match in the same cycle as the clear wins, so no event is lost. A separate read-only word returns the low 32 bits of the counter, so a core can take a quick 32-bit timestamp.

Top module: `wct_timer`

## Requirements
- R1: While `rst` is high, the counter, every armed bit, every fired bit, every `irq` line and `bus_rdata` are all cleared to zero.
- R2: The counter rises by exactly one on each clock edge at which `cnt_en` is high, and it holds its value when `cnt_en` is low.
- R3: A read strobe at word 0 returns the counter's low 32 bits, word 1 returns the high 32 bits, and word 2 is an alias that returns the low 32 bits. `bus_rdata` shows the counter value held at the clock edge that samples the strobe, one cycle after that strobe.
- R4: The control word is at word 3. Bit i (i = 0, 1) is channel i's armed bit and can be read and written. Bit 8+i is channel i's fired bit, and a read returns it.
- R5: Channel i's compare is staged at word 4+2i (low half) and word 5+2i (high half). Reads return the staged value. The staged value is copied into the active compare only by a control write that takes the armed bit from 0 to 1.
- R6: While channel i is armed and the counter is greater than or equal to the active compare, its fired bit sets on the next edge.
- R7: A disarmed channel never sets its fired bit. A compare write made while a channel is armed leaves the active compare, and so the firing time, unchanged.
- R8: A set fired bit stays set, even after a disarm, until a control write has a 1 in bit 8+i. A 0 in that bit has no effect.
- R9: When a clear of bit 8+i lands in the same cycle as a match on channel i, the fired bit stays set.
- R10: `irq[i]` is high exactly while channel i is both fired and armed. It stays level until the bit is cleared or the channel is disarmed.
- R11: The two channels are independent. Arming, matching or clearing one of them leaves the other's bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Global count enable |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 2 | Per-channel level interrupt |

## Verification
The checker watches several rules on every cycle: the counter steps by one while enabled, a fired bit rises only on an armed channel, an armed channel past its compare always shows fired (a clear in the same cycle does not stop it), the fired bit is sticky, the active compare stays fixed while a channel is armed, and `irq` equals fired AND armed. The bus ordering is something only the bench scenarios can show: which word holds which half, the one-cycle read latency, and the fact that a compare write has no effect until re-arm. They also show that the enable and the clear work per channel, and that a write of zero to a fired bit does nothing. For firing, the bench stops the counter around a random compare offset, which makes the expected fired state exact.

// File: rtl/wct_pkg.sv
package wct_pkg;
  localparam int BUS_W = 32;
  localparam int A_CNT_LO  = 0;
  localparam int A_CNT_HI  = 1;
  localparam int A_CNT_32  = 2;
  localparam int A_CTRL    = 3;
  localparam int A_CMP_BASE = 4;
  localparam int TRIG_SHIFT = 8;

  function automatic int cmp_lo_addr(input int ch);
    return A_CMP_BASE + 2 * ch;
  endfunction
endpackage

// File: rtl/wct_counter.sv
module wct_counter #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)     cnt_q <= '0;
    else if (en) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wct_channel.sv
module wct_channel #(
  parameter int CW = 64,
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  input  logic          ctl_wr,
  input  logic          arm_val,
  input  logic          clr,
  output logic          arm,
  output logic          trig,
  output logic          irq,
  output logic [CW-1:0] stage,
  output logic [CW-1:0] active
);
  logic          arm_q, trig_q, irq_q;
  logic [CW-1:0] stage_q, act_q;
  logic          hit, arm_d, trig_d, load;

  always_comb begin
    hit    = arm_q && (cnt >= act_q);
    arm_d  = ctl_wr ? arm_val : arm_q;
    load   = ctl_wr && arm_val && !arm_q;
    if (hit)      trig_d = 1'b1;
    else if (clr) trig_d = 1'b0;
    else          trig_d = trig_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q   <= 1'b0;
      trig_q  <= 1'b0;
      irq_q   <= 1'b0;
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      if (wr_lo) stage_q[BW-1:0]  <= wdata;
      if (wr_hi) stage_q[CW-1:BW] <= wdata[CW-BW-1:0];
      if (load)  act_q <= stage_q;
      arm_q  <= arm_d;
      trig_q <= trig_d;
      irq_q  <= trig_d & arm_d;
    end
  end

  assign arm    = arm_q;
  assign trig   = trig_q;
  assign irq    = irq_q;
  assign stage  = stage_q;
  assign active = act_q;
endmodule

// File: rtl/wct_regif.sv
module wct_regif
  import wct_pkg::*;
#(
  parameter int CW  = 64,
  parameter int NCH = 2,
  parameter int AW  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [CW-1:0]     cnt,
  input  logic [NCH-1:0]    arm,
  input  logic [NCH-1:0]    trig,
  input  logic [NCH*CW-1:0] stage,
  output logic              ctl_wr,
  output logic [NCH-1:0]    wr_lo,
  output logic [NCH-1:0]    wr_hi,
  output logic [BUS_W-1:0]  rdata
);
  logic [BUS_W-1:0] rdata_q, rmux, ctrl_word;

  assign ctl_wr = bus_wr && (int'(bus_addr) == A_CTRL);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_dec
      assign wr_lo[i] = bus_wr && (int'(bus_addr) == cmp_lo_addr(i));
      assign wr_hi[i] = bus_wr && (int'(bus_addr) == cmp_lo_addr(i) + 1);
    end
  endgenerate

  always_comb begin
    ctrl_word = '0;
    for (int i = 0; i < NCH; i++) begin
      ctrl_word[i]              = arm[i];
      ctrl_word[TRIG_SHIFT + i] = trig[i];
    end
    case (int'(bus_addr))
      A_CNT_LO: rmux = cnt[BUS_W-1:0];
      A_CNT_HI: rmux = cnt[CW-1:BUS_W];
      A_CNT_32: rmux = cnt[BUS_W-1:0];
      A_CTRL:   rmux = ctrl_word;
      default:  rmux = '0;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (int'(bus_addr) == cmp_lo_addr(i))     rmux = stage[i*CW +: BUS_W];
      if (int'(bus_addr) == cmp_lo_addr(i) + 1) rmux = stage[i*CW+BUS_W +: BUS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rmux;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/wct_timer.sv
module wct_timer
  import wct_pkg::*;
#(
  parameter int CW  = 64,
  parameter int NCH = 2,
  parameter int AW  = $clog2(A_CMP_BASE + 2 * NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic [NCH-1:0]   irq
);
  logic [CW-1:0]     cnt;
  logic [NCH-1:0]    arm, trig, wr_lo, wr_hi;
  logic [NCH*CW-1:0] stage, cmp_act;
  logic              ctl_wr;

  wct_counter #(.CW(CW)) u_ctr (
    .clk(clk), .rst(rst), .en(cnt_en), .cnt(cnt)
  );

  wct_regif #(.CW(CW), .NCH(NCH), .AW(AW)) u_regif (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .cnt(cnt), .arm(arm), .trig(trig),
    .stage(stage), .ctl_wr(ctl_wr), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .rdata(bus_rdata)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      wct_channel #(.CW(CW), .BW(BUS_W)) u_ch (
        .clk(clk), .rst(rst), .cnt(cnt),
        .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(bus_wdata),
        .ctl_wr(ctl_wr), .arm_val(bus_wdata[i]),
        .clr(ctl_wr && bus_wdata[TRIG_SHIFT + i]),
        .arm(arm[i]), .trig(trig[i]), .irq(irq[i]),
        .stage(stage[i*CW +: CW]), .active(cmp_act[i*CW +: CW])
      );
    end
  endgenerate
endmodule

// File: rtl/wct_checker.sv
module wct_checker #(
  parameter int CW  = 64,
  parameter int NCH = 2,
  parameter int AW  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [CW-1:0]     cnt,
  input logic [NCH-1:0]    arm,
  input logic [NCH-1:0]    trig,
  input logic [NCH-1:0]    irq,
  input logic [NCH*CW-1:0] cmp_act
);
  logic ctrl_wr;
  assign ctrl_wr = bus_wr && (int'(bus_addr) == 3);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (cnt == '0 && arm == '0 && trig == '0 && irq == '0)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> cnt == $past(cnt) + 1'b1); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(cnt)); // R2

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_a
      AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        $rose(trig[i]) |-> $past(arm[i])); // R7
      AST_MATCH_SETS: assert property (@(posedge clk) disable iff (rst)
        (arm[i] && cnt >= cmp_act[i*CW +: CW]) |=> trig[i]); // R6
      AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (trig[i] && !(ctrl_wr && bus_wdata[8+i])) |=> trig[i]); // R8
      AST_ACT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        arm[i] |=> (!arm[i] || $stable(cmp_act[i*CW +: CW]))); // R7
      AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        irq[i] == (trig[i] && arm[i])); // R10
    end
  endgenerate
endmodule

bind wct_timer wct_checker #(.CW(CW), .NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt), .arm(arm),
  .trig(trig), .irq(irq), .cmp_act(cmp_act)
);

// File: tb/wct_timer_tb.sv
module wct_timer_tb;
  logic        clk = 0, rst = 1, cnt_en = 0, bus_wr = 0, bus_rd = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;
  logic [63:0] m_cnt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wct_timer u_dut (.clk(clk), .rst(rst), .cnt_en(cnt_en), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  // bench time-base model taken from R1/R2
  always @(posedge clk) begin
    if (rst) m_cnt <= 0;
    else if (cnt_en) m_cnt <= m_cnt + 1;
  end

  function automatic bit exp_fire(input longint unsigned now, input longint unsigned cmp);
    return now >= cmp;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1; bus_addr = 3'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d, output logic [63:0] snap);
    bus_rd = 1; bus_addr = 3'(a); snap = m_cnt;
    @(negedge clk);
    bus_rd = 0; d = bus_rdata;
  endtask

  task automatic run(input int k);
    cnt_en = 1;
    repeat (k) @(negedge clk);
    cnt_en = 0;
  endtask

  task automatic set_cmp(input int ch, input logic [63:0] v);
    wr(4 + 2*ch, v[31:0]);
    wr(5 + 2*ch, v[63:32]);
  endtask

  initial begin
    logic [31:0] d;
    logic [63:0] s, v, cmp;
    void'($urandom(32'h5eed));
    @(negedge clk); @(negedge clk);
    chk("R1 irq in reset", {62'b0, irq}, 0);
    chk("R1 rdata in reset", {32'b0, bus_rdata}, 0);
    rst = 0;
    @(negedge clk);
    rd(3, d, s); chk("R1 ctrl after reset", {32'b0, d}, 0);
    rd(0, d, s); chk("R1 counter after reset", {32'b0, d}, 0);
    // R2 hold and step, R3 words
    repeat (3) @(negedge clk);
    rd(0, d, s); chk("R2 hold while disabled", {32'b0, d}, 0);
    run(37);
    rd(0, d, s); chk("R3 low word", {32'b0, d}, s[31:0]);
    rd(2, d, s); chk("R3 alias word", {32'b0, d}, s[31:0]);
    rd(1, d, s); chk("R3 high word", {32'b0, d}, s[63:32]);
    chk("R2 stepped count", s, 37);
    cnt_en = 1;
    rd(0, d, s); chk("R3 live low", {32'b0, d}, s[31:0]);
    rd(2, d, s); chk("R3 live alias", {32'b0, d}, s[31:0]);
    cnt_en = 0;
    // R5 staging readback, no effect until arm
    set_cmp(1, 64'hdead_beef_0123_4567);
    rd(6, d, s); chk("R5 cmp1 low", {32'b0, d}, 32'h0123_4567);
    rd(7, d, s); chk("R5 cmp1 high", {32'b0, d}, 32'hdead_beef);
    // R7 disarmed channel past its compare never fires
    set_cmp(0, 0);
    repeat (4) @(negedge clk);
    rd(3, d, s); chk("R7 disarmed no fire", {32'b0, d}, 0);
    // R6/R4: arm ch0 with future compare, then pass it
    v = m_cnt;
    set_cmp(0, v + 10);
    wr(3, 32'h1);
    run(9); repeat (2) @(negedge clk);
    rd(3, d, s); chk("R6 before compare", {32'b0, d}, 32'h1);
    run(1); repeat (2) @(negedge clk);
    rd(3, d, s); chk("R6 at compare", {32'b0, d}, 32'h101);
    chk("R10 irq ch0 only", {62'b0, irq}, 2'b01);
    chk("R11 ch1 untouched", {63'b0, d[9]}, 0);
    // R9: clear while match persists
    wr(3, 32'h101);
    @(negedge clk);
    rd(3, d, s); chk("R9 set beats clear", {32'b0, d}, 32'h101);
    // R8: disarm keeps fired, irq drops, w0 no effect, w1 clears
    wr(3, 32'h0); @(negedge clk);
    rd(3, d, s); chk("R8 sticky after disarm", {32'b0, d}, 32'h100);
    chk("R10 irq drops on disarm", {62'b0, irq}, 0);
    wr(3, 32'h0); @(negedge clk);
    rd(3, d, s); chk("R8 write zero no effect", {32'b0, d}, 32'h100);
    wr(3, 32'h100); @(negedge clk);
    rd(3, d, s); chk("R8 w1c clears", {32'b0, d}, 0);
    // R7: compare write while armed is held back until re-arm
    v = m_cnt;
    set_cmp(1, v + 1000);
    wr(3, 32'h2);
    set_cmp(1, 0);
    repeat (3) @(negedge clk);
    rd(3, d, s); chk("R7 armed write held", {32'b0, d}, 32'h2);
    chk("R10 no irq", {62'b0, irq}, 0);
    wr(3, 32'h0); wr(3, 32'h2); repeat (2) @(negedge clk);
    rd(3, d, s); chk("R5 re-arm loads", {32'b0, d}, 32'h202);
    chk("R10 irq ch1", {62'b0, irq}, 2'b10);
    wr(3, 32'h0); wr(3, 32'h200); @(negedge clk);
    // random firing offsets
    for (int it = 0; it < 40; it++) begin
      int ch = int'($urandom % 2);
      int dlt = int'($urandom % 20);
      int k = int'($urandom % 30);
      v = m_cnt;
      cmp = v + 64'(dlt);
      set_cmp(ch, cmp);
      wr(3, 32'(1 << ch));
      run(k); repeat (2) @(negedge clk);
      rd(3, d, s);
      chk(ch ? "R6 random ch1" : "R6 random ch0", {63'b0, d[8+ch]},
          {63'b0, exp_fire(64'(v) + 64'(k), cmp)});
      chk("R11 other channel idle", {63'b0, d[9-ch]}, 0);
      chk("R10 random irq", {63'b0, irq[ch]}, {63'b0, exp_fire(v + 64'(k), cmp)});
      wr(3, 32'h0); wr(3, 32'h300); @(negedge clk);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule